// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache that sits between a processor load/store port and a line-wide memory port. It holds 256 sets. Each set has two ways, and each way stores a 16-byte line with its own valid bit, dirty bit and tag. Each set also has one shared bit that names the way used most recently. A load or store that hits finishes in the cycle it is presented. Stores update only the cache and mark the line dirty. Memory is written when a dirty line is evicted.

On a miss the processor sees ready drop, and a small controller takes over. It picks a victim way. If that line is dirty, the controller writes it back over the memory port, then reads the missing line into the same way. Once the line is filled, the held request is served as an ordinary hit, one cycle after the fill. A store miss therefore allocates the line first and then merges its word. The processor must hold its request, address, write flag and write data steady until ready is seen high.

Top module: `dc2_cache`

## Requirements
- R1: The address splits into a tag in bits 31:12, a set index in bits 11:4 and a byte offset in bits 3:0. The 32-bit word within a line is chosen by bits 3:2, with word 0 in line bits 31:0.
- R2: A request hits only when a way in the indexed set is valid and holds the same tag. On a hit, cpuReady is high and cpuRdata holds the addressed word in the same cycle, and no memory request is made.
- R3: A store hit writes the addressed word of the hitting line and marks that way dirty. Later loads return the stored word.
- R4: Every hit and every fill makes the accessed way the set's most recent way. When both ways are valid, a miss replaces the way that is not the most recent.
- R5: On a miss, an invalid way is filled before any valid way is replaced. Way 0 is filled when both ways are invalid.
- R6: A dirty victim is written back first, with memWe high, address {victim tag, set, 4'h0} and the whole line as data. The read of the new line follows. A clean victim causes no write.
- R7: A store miss reads the line in, then merges the stored word and marks the line dirty.
- R8: cpuReady is low from the cycle a miss is detected until the access completes. The access completes in the cycle after the fill acknowledge.
- R9: memReq stays high, with memAddr and memWe unchanged, until memAck is seen. Every memory address has a zero byte offset. memAck completes one transfer.
- R10: Reset clears every valid bit, dirty bit and recency bit. After reset, every access misses without a write-back, and the idle port shows cpuReady high and memReq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuReq | input | 1 | Processor access request, held until ready |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid while cpuReady is high on a hit |
| cpuReady | output | 1 | Access completes in this cycle |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = line write-back, 0 = line read |
| memAddr | output | 32 | Line address of the transfer |
| memWdata | output | 128 | Line being written back |
| memRdata | input | 128 | Line returned on a read acknowledge |
| memAck | input | 1 | Memory completes the current transfer |

## Verification
If the recency bit is wrong, the wrong way is evicted. The port shows this at the next conflicting miss: either an unexpected write-back address appears on the memory port, or a line that should still be cached misses and the stall length changes. A lost dirty bit or a stale data word does not show until the line is evicted and read back, so the bench forces eviction and re-reads each stored word. A valid bit that survives reset, or a dirty bit that is not cleared, shows on the first access after reset as a zero-length stall or a spurious write. Stall lengths are checked exactly: 0 cycles for a hit, 5 for a clean miss and 9 for a dirty miss with the bench memory.

// File: rtl/dc2_pkg.sv
package dc2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } state_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic hitDo;    // hit accepted: update recency
    logic storeDo;  // store hit: write word, mark dirty
    logic fillDo;   // fill line into victim way
    logic wbSel;    // memory address from victim tag
  } strobe_t;
endpackage

// File: rtl/dc2_datapath.sv
module dc2_datapath
  import dc2_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 8,
  parameter int OFF_BITS = 4,
  parameter int WORD_W   = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  output logic [WORD_W-1:0]            cpuRdata,
  output logic                         hit,
  output logic                         victimDirty,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [(8<<OFF_BITS)-1:0]     memWdata,
  input  logic [(8<<OFF_BITS)-1:0]     memRdata
);
  localparam int SETS   = 1 << SET_BITS;
  localparam int TAG_W  = ADDR_W - SET_BITS - OFF_BITS;
  localparam int LINE_W = 8 << OFF_BITS;
  localparam int WLO    = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_BITS - WLO;

  logic [TAG_W-1:0]  tagQ  [2][SETS];
  logic [LINE_W-1:0] dataQ [2][SETS];
  logic [1:0]        validQ [SETS];
  logic [1:0]        dirtyQ [SETS];
  logic [SETS-1:0]   mruQ;

  logic [SET_BITS-1:0] idx;
  logic [TAG_W-1:0]    reqTag;
  logic [WSEL_W-1:0]   wSel;
  logic [1:0]          wayHit;
  logic                hitWay;
  logic                victim;
  logic                unusedLowBits;

  assign idx           = cpuAddr[OFF_BITS +: SET_BITS];
  assign reqTag        = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wSel          = cpuAddr[WLO +: WSEL_W];
  assign unusedLowBits = ^cpuAddr[WLO-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign wayHit[w] = validQ[idx][w] && (tagQ[w][idx] == reqTag);
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  always_comb begin
    if (!validQ[idx][0])      victim = 1'b0;
    else if (!validQ[idx][1]) victim = 1'b1;
    else                      victim = ~mruQ[idx];
  end

  assign victimDirty = dirtyQ[idx][victim];
  assign cpuRdata    = dataQ[hitWay][idx][WORD_W*int'(wSel) +: WORD_W];
  assign memWdata    = dataQ[victim][idx];
  assign memAddr     = strb.wbSel ? {tagQ[victim][idx], idx, {OFF_BITS{1'b0}}}
                                  : {reqTag, idx, {OFF_BITS{1'b0}}};

  // state bits that reset clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
      end
      mruQ <= '0;
    end else begin
      if (strb.hitDo) mruQ[idx] <= hitWay;
      if (strb.storeDo) dirtyQ[idx][hitWay] <= 1'b1;
      if (strb.fillDo) begin
        validQ[idx][victim] <= 1'b1;
        dirtyQ[idx][victim] <= 1'b0;
        mruQ[idx]           <= victim;
      end
    end
  end

  // tag and data storage, no reset
  always_ff @(posedge clk) begin
    if (strb.storeDo) dataQ[hitWay][idx][WORD_W*int'(wSel) +: WORD_W] <= cpuWdata;
    if (strb.fillDo) begin
      dataQ[victim][idx] <= memRdata;
      tagQ[victim][idx]  <= reqTag;
    end
  end
endmodule

// File: rtl/dc2_control.sv
module dc2_control
  import dc2_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    cpuWe,
  input  logic    hit,
  input  logic    victimDirty,
  input  logic    memAck,
  output strobe_t strb,
  output logic    cpuReady,
  output logic    memReq,
  output logic    memWe
);
  state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strb     = '0;
    cpuReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        cpuReady     = !cpuReq || hit;
        strb.hitDo   = cpuReq && hit;
        strb.storeDo = cpuReq && hit && cpuWe;
        if (cpuReq && !hit) stateD = victimDirty ? ST_WBACK : ST_FILL;
      end
      ST_WBACK: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        strb.wbSel = 1'b1;
        if (memAck) stateD = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.fillDo = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dc2_cache.sv
module dc2_cache
  import dc2_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 8,
  parameter int OFF_BITS = 4,
  parameter int WORD_W   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [WORD_W-1:0]        cpuWdata,
  output logic [WORD_W-1:0]        cpuRdata,
  output logic                     cpuReady,
  output logic                     memReq,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [(8<<OFF_BITS)-1:0] memWdata,
  input  logic [(8<<OFF_BITS)-1:0] memRdata,
  input  logic                     memAck
);
  strobe_t strb;
  logic    hit;
  logic    victimDirty;

  dc2_control u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .victimDirty(victimDirty), .memAck(memAck), .strb(strb),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe)
  );

  dc2_datapath #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .hit(hit), .victimDirty(victimDirty), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );
endmodule

// File: rtl/dc2_checker.sv
module dc2_checker #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr
);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady);

  p_done_after_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck && cpuReq) |=> cpuReady);

  p_req_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  p_line_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFF_BITS-1:0] == '0));

  p_read_after_wb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (memReq && !memWe));
endmodule

bind dc2_cache dc2_checker #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuReady(cpuReady),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memAddr(memAddr)
);

// File: tb/dc2_cache_test.sv
module dc2_cache_test;
  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  expLat;   // 0 hit, 5 clean miss, 9 dirty miss
    logic        expWb;
    logic [31:0] wbAddr;
  } vec_t;

  localparam int NROWS = 20;
  localparam vec_t VEC [NROWS] = '{
    '{1'b0, 32'h10010058, 32'h0,        4'd5, 1'b0, 32'h0},         // R10 R5 first fill way0
    '{1'b0, 32'h10010050, 32'h0,        4'd0, 1'b0, 32'h0},         // R2 hit
    '{1'b0, 32'h25371054, 32'h0,        4'd5, 1'b0, 32'h0},         // R5 second way
    '{1'b1, 32'h1001005C, 32'h0,        4'd0, 1'b0, 32'h0},         // R3 store hit
    '{1'b0, 32'h33431050, 32'h0,        4'd5, 1'b0, 32'h0},         // R4 evict clean B
    '{1'b0, 32'h1001005C, 32'h0,        4'd0, 1'b0, 32'h0},         // R3 R4 A kept
    '{1'b0, 32'h25371054, 32'h0,        4'd5, 1'b0, 32'h0},         // R4 evict C
    '{1'b0, 32'h33431050, 32'h0,        4'd9, 1'b1, 32'h10010050},  // R6 dirty A out
    '{1'b0, 32'h1001005C, 32'h0,        4'd5, 1'b0, 32'h0},         // R6 data came back
    '{1'b1, 32'hABCDE7F4, 32'hDEADBEEF, 4'd5, 1'b0, 32'h0},         // R7 store miss
    '{1'b0, 32'hABCDE7F4, 32'h0,        4'd0, 1'b0, 32'h0},         // R7 merged
    '{1'b0, 32'hABCDE7F0, 32'h0,        4'd0, 1'b0, 32'h0},         // R1 word 0
    '{1'b0, 32'h001237F8, 32'h0,        4'd5, 1'b0, 32'h0},         // R5 way1
    '{1'b0, 32'h004567F0, 32'h0,        4'd9, 1'b1, 32'hABCDE7F0},  // R7 R5 dirty way0
    '{1'b0, 32'h004567FC, 32'h0,        4'd0, 1'b0, 32'h0},         // R1 word 3
    '{1'b0, 32'hABCDE7F4, 32'h0,        4'd5, 1'b0, 32'h0},         // R6 refetch
    '{1'b0, 32'hFFFFFFFC, 32'h0,        4'd5, 1'b0, 32'h0},         // R1 top set/tag
    '{1'b0, 32'hFFFFFFF0, 32'h0,        4'd0, 1'b0, 32'h0},         // R2
    '{1'b1, 32'h00000000, 32'h12345678, 4'd5, 1'b0, 32'h0},         // R7 set 0
    '{1'b0, 32'h00000000, 32'h0,        4'd0, 1'b0, 32'h0}          // R3
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuReq = 1'b0;
  logic         cpuWe = 1'b0;
  logic [31:0]  cpuAddr = '0;
  logic [31:0]  cpuWdata = '0;
  logic [31:0]  cpuRdata;
  logic         cpuReady;
  logic         memReq;
  logic         memWe;
  logic [31:0]  memAddr;
  logic [127:0] memWdata;
  logic [127:0] memRdata = '0;
  logic         memAck = 1'b0;

  int total = 0;
  int bad   = 0;

  logic [127:0] memStore [logic [27:0]];
  logic [31:0]  refWords [logic [29:0]];
  logic         evWe [$];
  logic [31:0]  evAddr [$];
  int           waitCnt = 0;

  always #2 clk = ~clk;

  dc2_cache uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [31:0] patWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3C3C3C3;
  endfunction

  function automatic logic [127:0] lineOf(input logic [31:0] a);
    logic [127:0] r;
    if (memStore.exists(a[31:4])) return memStore[a[31:4]];
    for (int k = 0; k < 4; k++) r[k*32 +: 32] = patWord({a[31:4], 4'h0} + 32'(k*4));
    return r;
  endfunction

  function automatic logic [31:0] refRead(input logic [31:0] a);
    if (refWords.exists(a[31:2])) return refWords[a[31:2]];
    return patWord(a);
  endfunction

  // memory model: acknowledges on the third cycle a request is seen
  always @(posedge clk) begin
    if (!rstN) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memAck) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt == 2) begin
        memAck <= 1'b1;
        evWe.push_back(memWe);
        evAddr.push_back(memAddr);
        if (memWe) memStore[memAddr[31:4]] = memWdata;
        else       memRdata <= lineOf(memAddr);
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic doAccess(input logic we, input logic [31:0] addr, input logic [31:0] wdata,
                          output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    lat = 0;
    #1;
    while (!cpuReady) begin
      @(negedge clk);
      #1;
      lat++;
    end
    rd = cpuRdata;
    @(posedge clk);
    #1;
    cpuReq = 1'b0;
    cpuWe  = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    int base;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10: idle state after reset
    chk(cpuReady === 1'b1, "R10 ready idle", 32'(cpuReady), 32'd1);
    chk(memReq === 1'b0, "R10 memReq idle", 32'(memReq), 32'd0);

    for (int i = 0; i < NROWS; i++) begin
      base = evWe.size();
      doAccess(VEC[i].we, VEC[i].addr, VEC[i].wdata, rd, lat);
      // R2 R8: stall length
      chk(lat == int'(VEC[i].expLat), $sformatf("R8 stall row %0d", i), 32'(lat), 32'(VEC[i].expLat));
      if (!VEC[i].we)
        chk(rd === refRead(VEC[i].addr), $sformatf("R2 R3 load data row %0d", i), rd, refRead(VEC[i].addr));
      else
        refWords[VEC[i].addr[31:2]] = VEC[i].wdata;
      @(negedge clk);
      // R6 R9: memory traffic of this access
      if (VEC[i].expLat == 0) begin
        chk(evWe.size() == base, $sformatf("R2 no traffic row %0d", i), 32'(evWe.size() - base), 32'd0);
      end else if (VEC[i].expWb) begin
        chk(evWe.size() == base + 2, $sformatf("R6 two transfers row %0d", i), 32'(evWe.size() - base), 32'd2);
        if (evWe.size() == base + 2) begin
          chk(evWe[base] == 1'b1 && evAddr[base] == VEC[i].wbAddr,
              $sformatf("R6 write-back first row %0d", i), evAddr[base], VEC[i].wbAddr);
          chk(evWe[base+1] == 1'b0 && evAddr[base+1] == {VEC[i].addr[31:4], 4'h0},
              $sformatf("R6 fill after row %0d", i), evAddr[base+1], {VEC[i].addr[31:4], 4'h0});
        end
      end else begin
        chk(evWe.size() == base + 1, $sformatf("R6 one transfer row %0d", i), 32'(evWe.size() - base), 32'd1);
        if (evWe.size() == base + 1)
          chk(evWe[base] == 1'b0 && evAddr[base] == {VEC[i].addr[31:4], 4'h0},
              $sformatf("R9 fill address row %0d", i), evAddr[base], {VEC[i].addr[31:4], 4'h0});
      end
    end

    // R6: written-back line content for the evicted store line
    chk(memStore.exists(28'hABCDE7F) && memStore[28'hABCDE7F][63:32] == 32'hDEADBEEF,
        "R6 write-back data", memStore.exists(28'hABCDE7F) ? memStore[28'hABCDE7F][63:32] : 32'h0,
        32'hDEADBEEF);

    // R10: dirty line in set 0 way0, then reset
    doAccess(1'b1, 32'h00000004, 32'h0BADF00D, rd, lat);
    chk(lat == 0, "R3 store hit set0", 32'(lat), 32'd0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cpuReady === 1'b1 && memReq === 1'b0, "R10 idle after reset", 32'({cpuReady, memReq}), 32'h2);
    base = evWe.size();
    doAccess(1'b0, 32'h004567FC, 32'h0, rd, lat);
    chk(lat == 5, "R10 valid cleared", 32'(lat), 32'd5);
    chk(rd === refRead(32'h004567FC), "R10 data after reset", rd, refRead(32'h004567FC));
    base = evWe.size();
    doAccess(1'b0, 32'h00001004, 32'h0, rd, lat);
    @(negedge clk);
    chk(lat == 5, "R10 dirty cleared stall", 32'(lat), 32'd5);
    chk(evWe.size() == base + 1 && evWe[base] == 1'b0, "R10 no write-back after reset",
        32'(evWe.size() - base), 32'd1);
    chk(rd === patWord(32'h00001004), "R10 fresh line data", rd, patWord(32'h00001004));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule